// File: doc/BRIEF.md
# Hot-Swap Gate Protection Sequencer

This block is the digital sequencer behind the gate of a hot-swap pass switch. Its inputs are comparator results that have already been digitized: charge pump ready, enable, overvoltage, limiter active, overcurrent and fast trip. The block first waits a start-up delay once the charge pump is ready. It then hands the gate to an external regulation loop during inrush. After that it holds the gate fully on in regular operation. When a fault occurs it either turns the gate off for good or retries after a cool-down. The analog regulation loop and the limit arithmetic are outside the block.

Two up/down counters take the place of timing capacitors. Each counter adds 5 per tick while charging and subtracts 1 per tick while discharging. It saturates at a threshold and never goes below zero. One counter guards inrush and the other guards a sustained overcurrent. The parameter `VARIANT` sets the response to a fast trip: 0 restarts once and then latches off, 1 retries periodically, and 2 latches off at once.

Top module: `hsw_gate_ctrl`

## Requirements
- R1: After reset the state code `state_o` is 0 (idle), every gate and flag output is low, and both timers read 0. The state codes are: idle 0, start delay 1, inrush 2, regular 3, overcurrent fault 4, pulldown pulse 5, latched 6, retry 7.
- R2: From idle with `en` and `cp_up` both high, the block spends `START_DLY` cycles in state 1 and then enters inrush (2). If `cp_up` drops during state 1, the block returns to idle (0) and stays there.
- R3: In inrush, `gate_reg` is high. Per tick, the inrush timer adds 5 while `lim_act` is high and subtracts 1 otherwise. It saturates at `TMR_THR`, never goes below 0, and never exceeds `TMR_THR`. When `lim_act` is low and the timer is 0, the block moves to regular (3).
- R4: When the inrush timer reaches `TMR_THR`, the block leaves inrush with the gate off. It goes to retry (7) for variant 1 and to latched (6) for variants 0 and 2.
- R5: In regular, `gate_on` is high and both timers discharge. An active `oc` moves the block to fault (4) on the next edge.
- R6: In fault, `gate_on` stays high and the fault timer adds 5 per tick. If `oc` clears first, the block returns to regular (3). When the fault timer reaches `TMR_THR`, the block goes to latched (6) for variants 0 and 2 and to retry (7) for variant 1.
- R7: An `ftrip` in regular or fault moves the block to state 5. There `pd_pulse` is high and both gate outputs are low for `PULSE_LEN` cycles. After the pulse, variant 2 latches and variant 1 re-enters inrush. Variant 0 re-enters inrush the first time and latches on the second trip.
- R8: In latched, both gate outputs are low, `latched_flt` is high and the timers discharge. The block stays latched while `en` stays high. When `en` goes low and then high again, with `cp_up` held high throughout, the block re-enters inrush one cycle later without the start delay.
- R9: In retry, both gate outputs are low. The inrush timer is charged to threshold and discharged to 0 `RETRY_N` times. The block then re-enters inrush. From an inrush timeout this takes (`TMR_THR`+2) + (`RETRY_N`-1)·(ceil(`TMR_THR`/5) + `TMR_THR` + 2) cycles at one tick per cycle.
- R10: While `ov` is high, `gate_reg` and `gate_on` are low in the same cycle. The state is not changed by `ov`.
- R11: `en` low in any state gives idle (0) on the next edge, with both timers at 0 and `latched_flt` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Hot-swap enable |
| cp_up | input | 1 | Charge pump ready |
| ov | input | 1 | Overvoltage flag |
| lim_act | input | 1 | External loop is limiting current or power |
| oc | input | 1 | Current above the limit threshold |
| ftrip | input | 1 | Current above the fast-trip threshold |
| gate_reg | output | 1 | Gate handed to the regulation loop (inrush) |
| gate_on | output | 1 | Gate driven fully on |
| pd_pulse | output | 1 | Strong gate pulldown pulse |
| latched_flt | output | 1 | Latched-off fault indication |
| state_o | output | 3 | State code |
| inr_tmr | output | TMR_W | Inrush timer value |
| flt_tmr | output | TMR_W | Fault timer value |

## Verification
Every state change and every timer update appears one edge after the inputs that cause it. The exceptions are the `ov` masking of the gate outputs, which acts in the same cycle, and the start delay, pulse and retry windows, whose lengths come from the parameters. The bench drives its inputs on the falling edge and checks on the next falling edge. It counts the exact number of steps for each window with the closed forms given in the requirements, and it checks `ov` masking after a short delay with no clock edge in between. During random stimulus, the per-cycle checks compare against the input values of the previous step. This matches the single register between input and state.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_INR   = 3'd2,
    ST_REG   = 3'd3,
    ST_FLT   = 3'd4,
    ST_PULSE = 3'd5,
    ST_LATCH = 3'd6,
    ST_RETRY = 3'd7
  } hsw_state_e;

  localparam int unsigned VAR_ONCE  = 0;
  localparam int unsigned VAR_RETRY = 1;
  localparam int unsigned VAR_LATCH = 2;

  localparam int unsigned TMR_CHG = 5;
  localparam int unsigned TMR_DIS = 1;

  // One timer step: saturating charge, floored discharge.
  function automatic int unsigned tmr_next(input int unsigned cur, input logic up,
                                           input int unsigned thr);
    if (up) return (cur + TMR_CHG >= thr) ? thr : cur + TMR_CHG;
    return (cur == 0) ? 0 : cur - TMR_DIS;
  endfunction

endpackage

// File: rtl/hsw_tick_gen.sv
module hsw_tick_gen #(
  parameter int unsigned TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pc;
  logic          wrap;

  assign wrap = (pc == PW'(TICK_DIV - 1));
  assign tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (wrap) pc <= '0;
    else           pc <= pc + 1'b1;
  end
endmodule

// File: rtl/hsw_updown_tmr.sv
module hsw_updown_tmr
  import hsw_pkg::*;
#(
  parameter int unsigned THR = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         clr,
  input  logic                         up,
  output logic [$clog2(THR+1)-1:0]     cnt,
  output logic                         expired,
  output logic                         zero
);
  localparam int unsigned TW = $clog2(THR + 1);

  assign expired = (32'(cnt) >= THR);
  assign zero    = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= TW'(tmr_next(32'(cnt), up, THR));
  end

  // R3: discharge stops at zero
  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zero && tick && !up && !clr |=> zero);
  // R3: charging below threshold always moves the count upward
  p_charge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && up && !clr && !expired |=> cnt > $past(cnt));
  // R3: the count never passes the threshold
  p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= THR);
endmodule

// File: rtl/hsw_seq_fsm.sv
module hsw_seq_fsm
  import hsw_pkg::*;
#(
  parameter int unsigned VARIANT   = VAR_ONCE,
  parameter int unsigned START_DLY = 10,
  parameter int unsigned PULSE_LEN = 6,
  parameter int unsigned RETRY_N   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cp_up,
  input  logic       lim_act,
  input  logic       oc,
  input  logic       ftrip,
  input  logic       inr_exp,
  input  logic       inr_zero,
  input  logic       flt_exp,
  input  logic       flt_zero,
  output hsw_state_e st,
  output logic       inr_clr,
  output logic       flt_clr,
  output logic       inr_up,
  output logic       flt_up
);
  localparam int unsigned WIN_MAX = (START_DLY > PULSE_LEN) ? START_DLY : PULSE_LEN;
  localparam int unsigned CW      = $clog2(WIN_MAX + 1);
  localparam int unsigned RW      = $clog2(RETRY_N + 1);
  localparam hsw_state_e  FAIL_ST = (VARIANT == VAR_RETRY) ? ST_RETRY : ST_LATCH;

  hsw_state_e    nxt;
  logic [CW-1:0] seq_cnt;
  logic [RW-1:0] rcnt;
  logic          primed, once_used, rt_up;

  // Named events for the assertions and for readability.
  logic ev_wait_done, ev_pulse_done, ev_retry_done, ev_trip;
  hsw_state_e pulse_dest;

  assign ev_wait_done  = (st == ST_WAIT)  && (seq_cnt == CW'(START_DLY - 1));
  assign ev_pulse_done = (st == ST_PULSE) && (seq_cnt == CW'(PULSE_LEN - 1));
  assign ev_retry_done = (st == ST_RETRY) && !rt_up && inr_zero && flt_zero
                         && (rcnt == RW'(RETRY_N - 1));
  assign ev_trip       = ((st == ST_REG) || (st == ST_FLT)) && ftrip;

  always_comb begin
    if (VARIANT == VAR_LATCH)      pulse_dest = ST_LATCH;
    else if (VARIANT == VAR_RETRY) pulse_dest = ST_INR;
    else                           pulse_dest = once_used ? ST_LATCH : ST_INR;
  end

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (en && cp_up) nxt = primed ? ST_INR : ST_WAIT;
      ST_WAIT:  if (!cp_up) nxt = ST_IDLE;
                else if (ev_wait_done) nxt = ST_INR;
      ST_INR:   if (inr_exp) nxt = FAIL_ST;
                else if (!lim_act && inr_zero) nxt = ST_REG;
      ST_REG:   if (ftrip) nxt = ST_PULSE;
                else if (oc) nxt = ST_FLT;
      ST_FLT:   if (ftrip) nxt = ST_PULSE;
                else if (flt_exp) nxt = FAIL_ST;
                else if (!oc) nxt = ST_REG;
      ST_PULSE: if (ev_pulse_done) nxt = pulse_dest;
      ST_LATCH: nxt = ST_LATCH;
      ST_RETRY: if (ev_retry_done) nxt = ST_INR;
      default:  nxt = ST_IDLE;
    endcase
    if (!en) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      seq_cnt   <= '0;
      primed    <= 1'b0;
      once_used <= 1'b0;
      rt_up     <= 1'b1;
      rcnt      <= '0;
    end else begin
      st <= nxt;
      if (nxt != st) seq_cnt <= '0;
      else if ((st == ST_WAIT) || (st == ST_PULSE)) seq_cnt <= seq_cnt + 1'b1;

      if (!cp_up) primed <= 1'b0;
      else if (ev_wait_done && en) primed <= 1'b1;

      if (st == ST_IDLE) once_used <= 1'b0;
      else if (ev_pulse_done && en && (pulse_dest == ST_INR)) once_used <= 1'b1;

      if (st != ST_RETRY) begin
        rt_up <= 1'b1;
        rcnt  <= '0;
      end else if (rt_up && inr_exp) begin
        rt_up <= 1'b0;
      end else if (!rt_up && inr_zero) begin
        rt_up <= 1'b1;
        rcnt  <= rcnt + 1'b1;
      end
    end
  end

  assign inr_clr = (st == ST_IDLE) || (st == ST_WAIT) || !en;
  assign flt_clr = inr_clr;
  assign inr_up  = ((st == ST_INR) && lim_act) || ((st == ST_RETRY) && rt_up);
  assign flt_up  = (st == ST_FLT);

  // R11: enable low always lands in idle
  p_en_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st == ST_IDLE);
  // R2: losing the charge pump during the delay aborts start-up
  p_wait_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) && en && !cp_up |=> st == ST_IDLE);
  // R4: inrush timeout exits to the variant's failure state
  p_inr_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INR) && en && inr_exp |=> st == FAIL_ST);
  // R5: overcurrent in regular enters fault
  p_oc_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REG) && en && oc && !ftrip |=> st == ST_FLT);
  // R6: overcurrent clearing before expiry returns to regular
  p_flt_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLT) && en && !oc && !ftrip && !flt_exp |=> st == ST_REG);
  // R7: fast trip always starts the pulldown pulse
  p_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trip && en |=> st == ST_PULSE);
  // R8: latched holds while enable stays high
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LATCH) && en |=> st == ST_LATCH);
  // R9: retry only leaves toward inrush or idle
  p_retry_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RETRY) |=> (st == ST_RETRY) || (st == ST_INR) || (st == ST_IDLE));
endmodule

// File: rtl/hsw_gate_ctrl.sv
module hsw_gate_ctrl
  import hsw_pkg::*;
#(
  parameter int unsigned VARIANT   = VAR_ONCE,
  parameter int unsigned TICK_DIV  = 50,
  parameter int unsigned TMR_THR   = 400,
  parameter int unsigned START_DLY = 190000,
  parameter int unsigned PULSE_LEN = 6300,
  parameter int unsigned RETRY_N   = 64,
  localparam int unsigned TMR_W    = $clog2(TMR_THR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cp_up,
  input  logic             ov,
  input  logic             lim_act,
  input  logic             oc,
  input  logic             ftrip,
  output logic             gate_reg,
  output logic             gate_on,
  output logic             pd_pulse,
  output logic             latched_flt,
  output logic [2:0]       state_o,
  output logic [TMR_W-1:0] inr_tmr,
  output logic [TMR_W-1:0] flt_tmr
);
  hsw_state_e       st;
  logic             tick;
  logic [1:0]       t_clr, t_up, t_exp, t_zero;
  logic [TMR_W-1:0] t_cnt [2];

  hsw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  // Index 0: inrush timer, index 1: fault timer.
  for (genvar gi = 0; gi < 2; gi++) begin : g_tmr
    hsw_updown_tmr #(.THR(TMR_THR)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .clr(t_clr[gi]), .up(t_up[gi]),
      .cnt(t_cnt[gi]), .expired(t_exp[gi]), .zero(t_zero[gi])
    );
  end

  hsw_seq_fsm #(
    .VARIANT(VARIANT), .START_DLY(START_DLY),
    .PULSE_LEN(PULSE_LEN), .RETRY_N(RETRY_N)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .cp_up(cp_up),
    .lim_act(lim_act), .oc(oc), .ftrip(ftrip),
    .inr_exp(t_exp[0]), .inr_zero(t_zero[0]),
    .flt_exp(t_exp[1]), .flt_zero(t_zero[1]),
    .st(st),
    .inr_clr(t_clr[0]), .flt_clr(t_clr[1]),
    .inr_up(t_up[0]), .flt_up(t_up[1])
  );

  assign gate_reg    = (st == ST_INR) && !ov;
  assign gate_on     = ((st == ST_REG) || (st == ST_FLT)) && !ov;
  assign pd_pulse    = (st == ST_PULSE);
  assign latched_flt = (st == ST_LATCH);
  assign state_o     = st;
  assign inr_tmr     = t_cnt[0];
  assign flt_tmr     = t_cnt[1];

  // R10: overvoltage blanks both gate drives
  p_ov_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ov |-> !gate_on && !gate_reg);
  // R7: the pulldown pulse never overlaps a gate drive
  p_pulse_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pulse |-> !gate_on && !gate_reg);
  // R8: a latched block keeps the fault timer draining
  p_latch_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latched_flt && en |=> flt_tmr <= $past(flt_tmr));
endmodule

// File: tb/test_hsw_gate_ctrl.sv
module test_hsw_gate_ctrl;
  localparam int THR = 20;
  localparam int SD  = 10;
  localparam int PL  = 6;
  localparam int RN  = 64;
  localparam int TW  = $clog2(THR + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, cp_up = 0, ov = 0, lim_act = 0, oc = 0, ftrip = 0;

  logic          g_reg [3];
  logic          g_on  [3];
  logic          pd    [3];
  logic          lat   [3];
  logic [2:0]    st    [3];
  logic [TW-1:0] it    [3];
  logic [TW-1:0] ft    [3];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Index v is the variant: 0 restart once, 1 retry, 2 immediate latch.
  for (genvar gv = 0; gv < 3; gv++) begin : g_dut
    hsw_gate_ctrl #(
      .VARIANT(gv), .TICK_DIV(1), .TMR_THR(THR),
      .START_DLY(SD), .PULSE_LEN(PL), .RETRY_N(RN)
    ) i_hsw_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .cp_up(cp_up), .ov(ov),
      .lim_act(lim_act), .oc(oc), .ftrip(ftrip),
      .gate_reg(g_reg[gv]), .gate_on(g_on[gv]), .pd_pulse(pd[gv]),
      .latched_flt(lat[gv]), .state_o(st[gv]),
      .inr_tmr(it[gv]), .flt_tmr(ft[gv])
    );
  end

  function automatic int chg(input int x);
    return (x + 5 >= THR) ? THR : x + 5;
  endfunction
  function automatic int fail_code(input int v);
    return (v == 1) ? 7 : 6;
  endfunction
  function automatic int retry_len();
    return (THR + 2) + (RN - 1) * ((THR + 4) / 5 + THR + 2);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; en = 0; cp_up = 0; ov = 0; lim_act = 0; oc = 0; ftrip = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  initial begin
    int e;
    int rnd;
    bit prev_en;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    for (int v = 0; v < 3; v++) begin
      chk(int'(st[v]), 0, "R1 state");
      chk(int'(g_reg[v]) + int'(g_on[v]) + int'(pd[v]) + int'(lat[v]), 0, "R1 outputs");
      chk(int'(it[v]) + int'(ft[v]), 0, "R1 timers");
    end

    // Start-up delay then inrush timeout
    en = 1; cp_up = 1; lim_act = 1;
    step(SD);
    for (int v = 0; v < 3; v++) chk(int'(st[v]), 1, "R2 still delaying");
    step(1);
    for (int v = 0; v < 3; v++) begin
      chk(int'(st[v]), 2, "R2 inrush entry");
      chk(int'(g_reg[v]), 1, "R3 gate_reg in inrush");
    end
    e = 0;
    for (int k = 0; k < 4; k++) begin
      step(1);
      e = chg(e);
      for (int v = 0; v < 3; v++) chk(int'(it[v]), e, "R3 inrush charge");
    end
    step(1);
    for (int v = 0; v < 3; v++) begin
      chk(int'(st[v]), fail_code(v), "R4 timeout destination");
      chk(int'(g_reg[v]) + int'(g_on[v]), 0, "R4 gate off");
    end
    step(5);
    chk(int'(lat[0]), 1, "R8 latched flag");
    chk(int'(it[0]), THR - 5, "R8 timer drains");
    chk(int'(st[2]), 6, "R8 latched holds");
    step(retry_len() - 6);
    chk(int'(st[1]), 7, "R9 still retrying");
    chk(int'(g_reg[1]) + int'(g_on[1]), 0, "R9 gate off in retry");
    step(1);
    chk(int'(st[1]), 2, "R9 retry back to inrush");
    chk(int'(st[0]), 6, "R8 latched after long wait");
    en = 0;
    step(1);
    for (int v = 0; v < 3; v++) begin
      chk(int'(st[v]), 0, "R11 idle on enable low");
      chk(int'(lat[v]), 0, "R11 no latched flag");
      chk(int'(it[v]) + int'(ft[v]), 0, "R11 timers cleared");
    end
    en = 1;
    step(1);
    for (int v = 0; v < 3; v++) chk(int'(st[v]), 2, "R8 re-enable skips delay");

    // Discharge, regular and fault
    do_reset();
    en = 1; cp_up = 1; lim_act = 1;
    step(SD + 1);
    step(2);
    chk(int'(it[0]), 10, "R3 two charge ticks");
    lim_act = 0;
    step(3);
    chk(int'(it[0]), 7, "R3 discharge by one");
    step(7);
    chk(int'(it[0]), 0, "R3 floor at zero");
    chk(int'(st[0]), 2, "R3 still inrush");
    step(1);
    for (int v = 0; v < 3; v++) begin
      chk(int'(st[v]), 3, "R3 to regular");
      chk(int'(g_on[v]), 1, "R5 gate_on in regular");
      chk(int'(g_reg[v]), 0, "R5 gate_reg low");
    end
    oc = 1;
    step(1);
    chk(int'(st[0]), 4, "R5 overcurrent enters fault");
    chk(int'(g_on[0]), 1, "R6 gate_on in fault");
    step(2);
    chk(int'(ft[0]), 10, "R6 fault timer charges");
    oc = 0;
    step(1);
    chk(int'(st[0]), 3, "R6 recovery to regular");
    chk(int'(ft[0]), 15, "R6 last charge tick");
    step(3);
    chk(int'(ft[0]), 12, "R5 timers discharge in regular");
    oc = 1;
    step(3);
    chk(int'(ft[0]), THR, "R6 fault timer at threshold");
    step(1);
    for (int v = 0; v < 3; v++) chk(int'(st[v]), fail_code(v), "R6 expiry destination");
    oc = 0;

    // Fast trip and overvoltage
    do_reset();
    en = 1; cp_up = 1;
    step(SD + 2);
    chk(int'(st[0]), 3, "R5 quick start to regular");
    ov = 1;
    #1;
    for (int v = 0; v < 3; v++) chk(int'(g_on[v]), 0, "R10 gate blanked same cycle");
    step(1);
    chk(int'(st[0]), 3, "R10 state unchanged");
    ov = 0;
    #1;
    chk(int'(g_on[0]), 1, "R10 gate back");
    ftrip = 1;
    step(1);
    ftrip = 0;
    for (int v = 0; v < 3; v++) begin
      chk(int'(st[v]), 5, "R7 pulse state");
      chk(int'(pd[v]), 1, "R7 pulse high");
      chk(int'(g_on[v]), 0, "R7 gate off in pulse");
    end
    step(PL - 1);
    chk(int'(pd[0]), 1, "R7 pulse length");
    step(1);
    chk(int'(st[0]), 2, "R7 once variant restarts");
    chk(int'(st[1]), 2, "R7 retry variant restarts");
    chk(int'(st[2]), 6, "R7 immediate latch");
    step(1);
    chk(int'(st[0]), 3, "R7 once back in regular");
    ftrip = 1;
    step(1);
    ftrip = 0;
    step(PL);
    chk(int'(st[0]), 6, "R7 second trip latches");
    chk(int'(st[1]), 2, "R7 retry variant restarts again");

    // Charge pump loss during delay
    do_reset();
    en = 1; cp_up = 1;
    step(3);
    chk(int'(st[0]), 1, "R2 delaying");
    cp_up = 0;
    step(1);
    chk(int'(st[0]), 0, "R2 abort on charge pump loss");
    step(5);
    chk(int'(st[0]), 0, "R2 blocked without charge pump");

    // Random stimulus with per-cycle checks
    do_reset();
    rnd = $urandom(32'd20611);
    prev_en = 0;
    for (int c = 0; c < 4000; c++) begin
      prev_en = en;
      rnd = $urandom();
      en      = (rnd % 97) != 0;
      cp_up   = ((rnd >> 8) % 41) != 0;
      ov      = ((rnd >> 14) % 13) == 0;
      lim_act = ((rnd >> 20) % 3) == 0;
      oc      = ((rnd >> 23) % 5) == 0;
      ftrip   = ((rnd >> 26) % 60) == 0;
      step(1);
      for (int v = 0; v < 3; v++) begin
        if (!en) chk(int'(st[v]), 0, "R11 random enable drop");
        chk(int'(lat[v]), int'(st[v] == 3'd6), "R8 random latched flag");
        chk(int'(pd[v]), int'(st[v] == 3'd5), "R7 random pulse flag");
        chk(int'(g_on[v]), int'((st[v] == 3'd3 || st[v] == 3'd4) && !ov), "R10 random gate_on");
        chk(int'(g_reg[v]), int'(st[v] == 3'd2 && !ov), "R10 random gate_reg");
        chk(int'(it[v] <= THR && ft[v] <= THR), 1, "R3 random timer bound");
      end
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule